// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps an effective address onto a physical page through a small set of programmable large-block windows, without consulting any page table. Two independent banks, each with a fixed number of entries (four by default), hold an upper word (tag, block size, privilege validity) and a lower word (real block base, attribute bits, protection). Instruction fetches search one bank and data accesses search the other.

The lookup is purely combinational: the effective address, the access class, the read/write intent and the privilege level go in, and the same cycle yields a hit or miss indication, the physical page address, the granted read and write rights, and a fault flag when the requested access is not allowed. When translation is switched off for the access class, the address goes straight through with full rights. A simple configuration port writes and reads any word of any entry; a write that changes an upper word trims the tag bits and the paired real-base bits that the new block size makes irrelevant.

A miss tells a downstream page-table search to start; the hit/miss pair is never both high.

Top module: `blkxlat_unit`

## Requirements
- R1: A fetch (`lk_fetch`=1) searches only the instruction bank (`cfg_dbank`=0); a data access searches only the data bank (`cfg_dbank`=1).
- R2: An entry can match only when effective-address bits 31:28 equal upper-word bits 31:28.
- R3: The block-size field is upper-word bits 12:2; field bit k masks effective-address bit 17+k. Effective-address bits 27:17 are compared with upper-word bits 27:17 only where the mask bit is 0.
- R4: A matching entry is valid in supervisor mode (`lk_user`=0) only if upper-word bit 1 is set, and in user mode only if upper-word bit 0 is set.
- R5: On a hit, physical bits 31:28 are lower-word bits 31:28; bits 27:17 are the OR of lower-word bits 27:17 and effective-address bits kept by the mask; bits 16:12 are effective-address bits 16:12; bits 11:0 are zero.
- R6: Lower-word bits 1:0 set rights on a hit: 00 none, 01 read only, 10 or 11 read and write.
- R7: `res_fault` is high exactly when a hit does not grant the requested access (write when `lk_write`=1, read otherwise).
- R8: With the class's enable low (`xlat_ins_en` for fetches, `xlat_dat_en` for data), `res_pa` is the effective address with bits 11:0 cleared, both rights are granted, and hit, miss and fault are low.
- R9: An upper-word write whose value differs from the stored one stores the value with bits 16:13 cleared and bits 27:17 cleared under the new mask; the paired lower word keeps bits 31:28, keeps bits 27:17 outside the mask, keeps bits 6:3 and 1:0, and clears every other bit. An upper-word write equal to the stored value changes nothing. A lower-word write stores the value unchanged.
- R10: When several valid entries match, the lowest-numbered one supplies the result.
- R11: `res_miss` is high when translation is enabled and no valid entry matches; miss outputs zero rights and a zero address.
- R12: `cfg_rdata` shows the word chosen by `cfg_dbank`, `cfg_idx` and `cfg_upper` in the same cycle; after reset every word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the entry registers |
| rst_n | input | 1 | Active-low reset, clears all entries |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_dbank | input | 1 | Bank select: 0 instruction, 1 data |
| cfg_idx | input | 2 | Entry index |
| cfg_upper | input | 1 | Word select: 1 upper, 0 lower |
| cfg_wdata | input | 32 | Write value |
| cfg_rdata | output | 32 | Read value of the selected word |
| xlat_ins_en | input | 1 | Translation enable for fetches |
| xlat_dat_en | input | 1 | Translation enable for data accesses |
| lk_ea | input | 32 | Effective address |
| lk_fetch | input | 1 | 1 for instruction fetch, 0 for data |
| lk_write | input | 1 | 1 for a write access |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor |
| res_hit | output | 1 | A valid entry matched |
| res_miss | output | 1 | Translation on and no valid entry matched |
| res_pa | output | 32 | Physical page address |
| res_rd_ok | output | 1 | Read permitted |
| res_wr_ok | output | 1 | Write permitted |
| res_fault | output | 1 | Hit without the requested right |

## Verification
Every cycle the assertions check that hit and miss never coincide, that the physical address is page aligned, that write rights imply read rights, that a fault only accompanies a hit, that bypass grants full rights with the address passed through, that at most one entry wins, and that stored upper words never carry tag bits under their own mask, with the paired real-base bits cleared after a changing upper write. Which entry wins among overlaps, the exact merge of address and real-base bits for various block sizes, the privilege gating, the bank chosen per access class and the no-change rule for a repeated upper write can only be shown by the bench's directed scenarios against its own model.

// File: rtl/blkxlat_pkg.sv
package blkxlat_pkg;

  localparam int WORD_W = 32;
  localparam int MASK_W = 11;

  // block-size mask aligned to effective-address bits 27:17
  function automatic logic [MASK_W-1:0] bx_len_mask(input logic [WORD_W-1:0] upr);
    return upr[12:2];
  endfunction

  function automatic logic bx_tag_hit(input logic [WORD_W-1:0] upr,
                                      input logic [WORD_W-1:0] ea);
    logic [MASK_W-1:0] m;
    m = bx_len_mask(upr);
    return (ea[31:28] == upr[31:28]) && ((ea[27:17] & ~m) == upr[27:17]);
  endfunction

  function automatic logic bx_valid(input logic [WORD_W-1:0] upr, input logic user);
    return user ? upr[0] : upr[1];
  endfunction

  function automatic logic [WORD_W-1:0] bx_phys(input logic [WORD_W-1:0] upr,
                                                input logic [WORD_W-1:0] lwr,
                                                input logic [WORD_W-1:0] ea);
    logic [MASK_W-1:0] m;
    m = bx_len_mask(upr);
    return {lwr[31:28], (ea[27:17] & m) | lwr[27:17], ea[16:12], 12'h000};
  endfunction

  function automatic logic bx_rd_ok(input logic [WORD_W-1:0] lwr);
    return lwr[1] | lwr[0];
  endfunction

  function automatic logic bx_wr_ok(input logic [WORD_W-1:0] lwr);
    return lwr[1];
  endfunction

  function automatic logic [WORD_W-1:0] bx_norm_upper(input logic [WORD_W-1:0] v);
    logic [MASK_W-1:0] m;
    m = bx_len_mask(v);
    return {v[31:28], v[27:17] & ~m, 4'b0000, v[12:0]};
  endfunction

  function automatic logic [WORD_W-1:0] bx_norm_lower(input logic [WORD_W-1:0] lwr,
                                                      input logic [WORD_W-1:0] v);
    logic [MASK_W-1:0] m;
    m = bx_len_mask(v);
    return {lwr[31:28], lwr[27:17] & ~m, 10'b0, lwr[6:3], 1'b0, lwr[1:0]};
  endfunction

endpackage

// File: rtl/blkxlat_bank.sv
module blkxlat_bank
  import blkxlat_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic                            wr_upper,
  input  logic [WORD_W-1:0]               wr_data,
  input  logic [IDX_W-1:0]                rd_idx,
  input  logic                            rd_upper,
  output logic [WORD_W-1:0]               rd_data,
  output logic [NUM_ENT-1:0][WORD_W-1:0]  ent_upr,
  output logic [NUM_ENT-1:0][WORD_W-1:0]  ent_lwr
);

  logic [NUM_ENT-1:0][WORD_W-1:0] upr_q;
  logic [NUM_ENT-1:0][WORD_W-1:0] lwr_q;
  logic [NUM_ENT-1:0]             upr_chg;
  logic [NUM_ENT-1:0]             lwr_wr;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    assign upr_chg[i] = wr_en && wr_upper && (wr_idx == IDX_W'(i)) && (wr_data != upr_q[i]);
    assign lwr_wr[i]  = wr_en && !wr_upper && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        upr_q[i] <= '0;
        lwr_q[i] <= '0;
      end else if (upr_chg[i]) begin
        upr_q[i] <= bx_norm_upper(wr_data);
        lwr_q[i] <= bx_norm_lower(lwr_q[i], wr_data);
      end else if (lwr_wr[i]) begin
        lwr_q[i] <= wr_data;
      end
    end

    AST_UPPER_TAG_TRIMMED: assert property (@(posedge clk) disable iff (!rst_n)
      (upr_q[i][27:17] & upr_q[i][12:2]) == '0);  // R9
    AST_LOWER_BASE_TRIMMED: assert property (@(posedge clk) disable iff (!rst_n)
      upr_chg[i] |=> (lwr_q[i][27:17] & upr_q[i][12:2]) == '0);  // R9
  end

  assign ent_upr = upr_q;
  assign ent_lwr = lwr_q;
  assign rd_data = rd_upper ? upr_q[rd_idx] : lwr_q[rd_idx];

endmodule

// File: rtl/blkxlat_match.sv
module blkxlat_match
  import blkxlat_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  logic [NUM_ENT-1:0][WORD_W-1:0] ent_upr,
  input  logic [NUM_ENT-1:0][WORD_W-1:0] ent_lwr,
  input  logic [WORD_W-1:0]              ea,
  input  logic                           user,
  output logic [NUM_ENT-1:0]             hit_vec,
  output logic [NUM_ENT-1:0]             win_vec,
  output logic                           any_hit,
  output logic [WORD_W-1:0]              sel_pa,
  output logic [1:0]                     sel_pp
);

  logic [NUM_ENT-1:0][WORD_W-1:0] pa_each;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign hit_vec[i] = bx_tag_hit(ent_upr[i], ea) && bx_valid(ent_upr[i], user);
    assign pa_each[i] = bx_phys(ent_upr[i], ent_lwr[i], ea);
  end

  // lowest index takes precedence
  always_comb begin
    logic found;
    found   = 1'b0;
    win_vec = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (hit_vec[i] && !found) begin
        win_vec[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    sel_pa = '0;
    sel_pp = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (win_vec[i]) begin
        sel_pa = sel_pa | pa_each[i];
        sel_pp = sel_pp | ent_lwr[i][1:0];
      end
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/blkxlat_unit.sv
module blkxlat_unit
  import blkxlat_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_dbank,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_upper,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              xlat_ins_en,
  input  logic              xlat_dat_en,
  input  logic [31:0]       lk_ea,
  input  logic              lk_fetch,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              res_hit,
  output logic              res_miss,
  output logic [31:0]       res_pa,
  output logic              res_rd_ok,
  output logic              res_wr_ok,
  output logic              res_fault
);

  localparam int NUM_BANK = 2;

  logic [NUM_BANK-1:0][NUM_ENT-1:0][WORD_W-1:0] bank_upr;
  logic [NUM_BANK-1:0][NUM_ENT-1:0][WORD_W-1:0] bank_lwr;
  logic [NUM_BANK-1:0][WORD_W-1:0]              bank_rd;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    blkxlat_bank #(.NUM_ENT(NUM_ENT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_dbank == 1'(b))),
      .wr_idx   (cfg_idx),
      .wr_upper (cfg_upper),
      .wr_data  (cfg_wdata),
      .rd_idx   (cfg_idx),
      .rd_upper (cfg_upper),
      .rd_data  (bank_rd[b]),
      .ent_upr  (bank_upr[b]),
      .ent_lwr  (bank_lwr[b])
    );
  end

  assign cfg_rdata = bank_rd[cfg_dbank];

  // one comparator array shared by both banks
  logic                           bank_sel;
  logic                           xlat_on;
  logic [NUM_ENT-1:0][WORD_W-1:0] sel_upr;
  logic [NUM_ENT-1:0][WORD_W-1:0] sel_lwr;
  logic [NUM_ENT-1:0]             hit_vec;
  logic [NUM_ENT-1:0]             win_vec;
  logic                           any_hit;
  logic [WORD_W-1:0]              m_pa;
  logic [1:0]                     m_pp;
  logic                           need_right;

  assign bank_sel = !lk_fetch;
  assign xlat_on  = lk_fetch ? xlat_ins_en : xlat_dat_en;
  assign sel_upr  = bank_upr[bank_sel];
  assign sel_lwr  = bank_lwr[bank_sel];

  blkxlat_match #(.NUM_ENT(NUM_ENT)) u_match (
    .ent_upr (sel_upr),
    .ent_lwr (sel_lwr),
    .ea      (lk_ea),
    .user    (lk_user),
    .hit_vec (hit_vec),
    .win_vec (win_vec),
    .any_hit (any_hit),
    .sel_pa  (m_pa),
    .sel_pp  (m_pp)
  );

  always_comb begin
    if (!xlat_on) begin
      res_hit   = 1'b0;
      res_miss  = 1'b0;
      res_pa    = {lk_ea[31:12], 12'h000};
      res_rd_ok = 1'b1;
      res_wr_ok = 1'b1;
    end else if (any_hit) begin
      res_hit   = 1'b1;
      res_miss  = 1'b0;
      res_pa    = m_pa;
      res_rd_ok = bx_rd_ok({30'b0, m_pp});
      res_wr_ok = bx_wr_ok({30'b0, m_pp});
    end else begin
      res_hit   = 1'b0;
      res_miss  = 1'b1;
      res_pa    = '0;
      res_rd_ok = 1'b0;
      res_wr_ok = 1'b0;
    end
  end

  assign need_right = lk_write ? res_wr_ok : res_rd_ok;
  assign res_fault  = res_hit && !need_right;

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_hit && res_miss));  // R11
  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    res_pa[11:0] == 12'h000);  // R5
  AST_WRITE_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_ok |-> res_rd_ok);  // R6
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |-> res_hit);  // R7
  AST_BYPASS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_on |-> (res_rd_ok && res_wr_ok && !res_miss && res_pa[31:12] == lk_ea[31:12]));  // R8
  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec) && ((win_vec & ~hit_vec) == '0));  // R10

endmodule

// File: tb/blkxlat_unit_bench.sv
module blkxlat_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_dbank = 1'b0, cfg_upper = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        xlat_ins_en = 1'b1, xlat_dat_en = 1'b1;
  logic [31:0] lk_ea = '0;
  logic        lk_fetch = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic        res_hit, res_miss, res_rd_ok, res_wr_ok, res_fault;
  logic [31:0] res_pa;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_upr [2][4];
  logic [31:0] m_lwr [2][4];

  always #4 clk = ~clk;

  blkxlat_unit u_blkxlat_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dbank(cfg_dbank),
    .cfg_idx(cfg_idx), .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .xlat_ins_en(xlat_ins_en), .xlat_dat_en(xlat_dat_en),
    .lk_ea(lk_ea), .lk_fetch(lk_fetch), .lk_write(lk_write), .lk_user(lk_user),
    .res_hit(res_hit), .res_miss(res_miss), .res_pa(res_pa),
    .res_rd_ok(res_rd_ok), .res_wr_ok(res_wr_ok), .res_fault(res_fault)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // configuration write with model update (R9 rules restated per bit)
  task automatic wr_reg(input bit dbank, input int idx, input bit upper, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dbank = dbank; cfg_idx = 2'(idx); cfg_upper = upper; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!upper) begin
      m_lwr[dbank][idx] = v;
    end else if (v != m_upr[dbank][idx]) begin
      logic [31:0] nu, nl;
      nu = v; nl = m_lwr[dbank][idx];
      for (int j = 13; j <= 16; j++) nu[j] = 1'b0;
      for (int j = 17; j <= 27; j++) if (v[j-15]) begin nu[j] = 1'b0; nl[j] = 1'b0; end
      nl[2] = 1'b0;
      for (int j = 7; j <= 16; j++) nl[j] = 1'b0;
      m_upr[dbank][idx] = nu;
      m_lwr[dbank][idx] = nl;
    end
  endtask

  task automatic rd_chk(input string req, input bit dbank, input int idx, input bit upper);
    @(negedge clk);
    cfg_dbank = dbank; cfg_idx = 2'(idx); cfg_upper = upper;
    #2;
    chk(req, "rdata", cfg_rdata, upper ? m_upr[dbank][idx] : m_lwr[dbank][idx]);
  endtask

  // reference lookup and comparison of all outputs
  task automatic look(input string req, input logic [31:0] ea, input bit fetch,
                      input bit wr, input bit user);
    bit e_hit, e_miss, e_rd, e_wr, e_flt, en;
    logic [31:0] e_pa;
    int b, win;
    @(negedge clk);
    lk_ea = ea; lk_fetch = fetch; lk_write = wr; lk_user = user;
    #2;
    b = fetch ? 0 : 1;
    en = fetch ? xlat_ins_en : xlat_dat_en;
    e_hit = 0; e_miss = 0; e_rd = 0; e_wr = 0; e_pa = '0; win = -1;
    if (!en) begin
      e_pa = ea & 32'hFFFF_F000; e_rd = 1; e_wr = 1;
    end else begin
      for (int k = 3; k >= 0; k--) begin
        logic [31:0] u;
        bit ok;
        u = m_upr[b][k];
        ok = (ea[31:28] == u[31:28]) && (user ? u[0] : u[1]);
        for (int j = 17; j <= 27; j++) if (!u[j-15] && ea[j] != u[j]) ok = 0;
        if (ok) win = k;
      end
      if (win < 0) e_miss = 1;
      else begin
        logic [31:0] u, l;
        u = m_upr[b][win]; l = m_lwr[b][win];
        e_hit = 1;
        e_pa[31:28] = l[31:28];
        for (int j = 17; j <= 27; j++) e_pa[j] = l[j] | (u[j-15] & ea[j]);
        e_pa[16:12] = ea[16:12];
        e_wr = l[1]; e_rd = l[1] | l[0];
      end
    end
    e_flt = e_hit && !(wr ? e_wr : e_rd);
    chk(req, "hit",   32'(res_hit),   32'(e_hit));
    chk(req, "miss",  32'(res_miss),  32'(e_miss));
    chk(req, "pa",    res_pa,         e_pa);
    chk(req, "rd_ok", 32'(res_rd_ok), 32'(e_rd));
    chk(req, "wr_ok", 32'(res_wr_ok), 32'(e_wr));
    chk(req, "fault", 32'(res_fault), 32'(e_flt));
  endtask

  task automatic t_reset();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4; i++) begin
        rd_chk("R12", b[0], i, 1'b1);
        rd_chk("R12", b[0], i, 1'b0);
      end
    look("R11", 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    look("R11", 32'h8000_1000, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_bypass();
    xlat_dat_en = 1'b0;
    look("R8", 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1);
    chk("R8", "pa literal", res_pa, 32'hDEAD_B000);
    look("R1", 32'h1234_5678, 1'b1, 1'b0, 1'b0);
    xlat_dat_en = 1'b1;
    xlat_ins_en = 1'b0;
    look("R8", 32'h0000_0FFF, 1'b1, 1'b0, 1'b0);
    xlat_ins_en = 1'b1;
  endtask

  task automatic t_basic();
    wr_reg(1, 0, 0, 32'h1234_0002);
    wr_reg(1, 0, 1, 32'h8000_0002);
    rd_chk("R9", 1, 0, 1'b1);
    rd_chk("R9", 1, 0, 1'b0);
    look("R5", 32'h8001_5ABC, 1'b0, 1'b1, 1'b0);
    chk("R5", "pa literal", res_pa, 32'h1235_5000);
    look("R4", 32'h8001_5ABC, 1'b0, 1'b0, 1'b1);
    look("R1", 32'h8001_5ABC, 1'b1, 1'b0, 1'b0);
    look("R2", 32'h9001_5ABC, 1'b0, 1'b0, 1'b0);
    look("R3", 32'h8002_0000, 1'b0, 1'b0, 1'b0);
    wr_reg(1, 0, 1, 32'h8000_0001);
    look("R4", 32'h8001_5ABC, 1'b0, 1'b0, 1'b1);
    look("R4", 32'h8001_5ABC, 1'b0, 1'b0, 1'b0);
    wr_reg(0, 2, 0, 32'h4000_0001);
    wr_reg(0, 2, 1, 32'h8000_0003);
    look("R1", 32'h8001_5ABC, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_mask();
    wr_reg(1, 1, 0, 32'h5007_FFFF);
    wr_reg(1, 1, 1, 32'h9006_E00E);
    rd_chk("R9", 1, 1, 1'b1);
    chk("R9", "upper literal", cfg_rdata, 32'h9000_000E);
    rd_chk("R9", 1, 1, 1'b0);
    chk("R9", "lower literal", cfg_rdata, 32'h5000_007B);
    look("R3", 32'h9007_F000, 1'b0, 1'b0, 1'b0);
    look("R3", 32'h9008_0000, 1'b0, 1'b0, 1'b0);
    look("R5", 32'h9002_3000, 1'b0, 1'b1, 1'b0);
    wr_reg(1, 1, 0, 32'hABCE_0003);
    wr_reg(1, 1, 1, 32'h9000_000E);
    rd_chk("R9", 1, 1, 1'b0);
    chk("R9", "same-value write", cfg_rdata, 32'hABCE_0003);
    wr_reg(1, 1, 1, 32'h0000_7FFE);
    look("R3", 32'h0FFF_F000, 1'b0, 1'b0, 1'b0);
    look("R5", 32'h0ABC_D000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_perm();
    for (int p = 0; p < 4; p++) begin
      wr_reg(0, 3, 0, 32'h7000_0000 | 32'(p));
      wr_reg(0, 3, 1, 32'hC000_0002);
      look("R6", 32'hC000_0000, 1'b1, 1'b0, 1'b0);
      look("R7", 32'hC000_0000, 1'b1, 1'b1, 1'b0);
      look("R7", 32'hC001_F000, 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_priority();
    wr_reg(1, 2, 0, 32'h2000_0002);
    wr_reg(1, 2, 1, 32'hA000_0002);
    wr_reg(1, 3, 0, 32'h3000_0001);
    wr_reg(1, 3, 1, 32'hA000_0002);
    look("R10", 32'hA001_0000, 1'b0, 1'b1, 1'b0);
    chk("R10", "winner pa", res_pa, 32'h2001_0000);
    wr_reg(1, 2, 1, 32'hA000_0001);
    look("R10", 32'hA001_0000, 1'b0, 1'b1, 1'b0);
    chk("R10", "second pa", res_pa, 32'h3001_0000);
  endtask

  initial begin : wdog
    #(200000 * 8);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4; i++) begin m_upr[b][i] = '0; m_lwr[b][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_basic();
    t_mask();
    t_perm();
    t_priority();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule